// File: doc/BRIEF.md
# Change-of-State Interrupt Controller

This block watches a vector of 32 asynchronous digital lines, split into four groups of eight: three bytes of isolated inputs and one byte of logic-level lines. Each line passes through a two-flop synchroniser. Its edges are found by comparing the synchronised value with the value from the clock before. When an edge of a kind enabled for that line's group is seen, a sticky per-bit status flag is latched. A registered level interrupt is raised while any flag is set.

Host software reads the 32-bit status word, then writes the same value back to a write-one-to-clear port. That port has a byte enable per group. Any edge that lands between the read and the write-back stays latched, because setting a bit beats clearing it in the same cycle. An 8-bit edge-enable register selects, for each group, detection of rising edges, falling edges or both. A single-cycle software reset pulse from outside the block clears every status flag.

Top module: `cos_irq_ctrl`

## Requirements
- R1: Status bit i belongs to the group i/8: bits 7:0 are inputs 0-7, bits 15:8 are inputs 8-15, bits 23:16 are inputs 16-23 and bits 31:24 are the logic-level lines 0-7. A bit is set when an enabled edge occurs on `din_i[i]` and stays set until it is cleared.
- R2: Enable bit g (0..3) turns on rising-edge detection for group g, and enable bit 4+g turns on falling-edge detection for the same group. With both bits set, either edge latches. An edge of a kind that is not enabled leaves the status unchanged.
- R3: The enable register resets to 8'h00. A write with `en_wr_i` loads `en_wdata_i` at the next edge, `en_o` reads the current value, and the register holds its value when no write is made.
- R4: A write with `clr_wr_i` clears each status bit whose data bit is 1 and whose byte enable `clr_be_i[g]` is 1. Bits written as 0, and bits in bytes that are not enabled, are unchanged. No status bit falls without such a write or a software reset.
- R5: When a bit's clear and a new enabled edge on that bit fall in the same cycle, the bit ends up set.
- R6: `irq_o` is a register equal to the OR of all status bits on the previous clock. It stays high until all 32 bits are clear. `irq_stat_o` always equals `irq_o`.
- R7: A `soft_rst_i` pulse clears all 32 status bits at the next edge and leaves the enable register unchanged.
- R8: The level the inputs hold when reset is released is not treated as an edge.
- R9: An input change present at clock edge k appears on `status_o` after edge k+2 and on `irq_o` after edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Single-cycle software reset pulse; clears status |
| din_i | input | 32 | Raw asynchronous input lines |
| en_wr_i | input | 1 | Write strobe for the edge-enable register |
| en_wdata_i | input | 8 | Enable data: [3:0] rising per group, [7:4] falling per group |
| en_o | output | 8 | Current edge-enable register value |
| clr_wr_i | input | 1 | Write strobe for the clear port |
| clr_be_i | input | 4 | Byte enables for the clear write, one per group |
| clr_data_i | input | 32 | Clear mask; a 1 clears the status bit |
| status_o | output | 32 | Sticky change-of-state flags |
| irq_o | output | 1 | Level interrupt |
| irq_stat_o | output | 1 | Read-only copy of the interrupt for polling |

## Verification
Mixed byte patterns are used in which some bits rise, some fall and some hold in each group. Running them with rising-only, falling-only and both-edge enables separates the decoding of the low and high enable nibbles and shows which group each byte belongs to. Partial byte enables and zero data bits in a clear write tell real write-one-to-clear behaviour apart from a blanket clear. An edge timed to land in the same cycle as its clear exposes which of set and clear takes priority. Inputs held high across reset release, and a single-bit latency probe, pin down the pipeline depth and the handling of the first cycles after reset.

// File: rtl/cos_irq_pkg.sv
package cos_irq_pkg;
  localparam int unsigned GROUP_W     = 8;
  localparam int unsigned SYNC_STAGES = 2;

  // Replicate one enable bit across a group.
  function automatic logic [GROUP_W-1:0] grp_fill(input logic b);
    return {GROUP_W{b}};
  endfunction
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cos_edge_det.sv
module cos_edge_det #(
  parameter int unsigned W         = 32,
  parameter int unsigned PRIME_CYC = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  localparam int unsigned CNT_W = $clog2(PRIME_CYC + 1);

  logic [W-1:0]     prev_q;
  logic [CNT_W-1:0] prime_q;
  logic             armed;

  // Edges stay masked until prev_q holds a real sample, so the level
  // present at reset release is not seen as an edge.
  assign armed = (prime_q == CNT_W'(PRIME_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      prime_q <= '0;
    end else begin
      prev_q <= d_i;
      if (!armed) prime_q <= prime_q + 1'b1;
    end
  end

  assign rise_o = armed ? (d_i & ~prev_q) : '0;
  assign fall_o = armed ? (~d_i & prev_q) : '0;
endmodule

// File: rtl/cos_status.sv
module cos_status
  import cos_irq_pkg::*;
#(
  parameter int unsigned N_GROUPS = 4,
  localparam int unsigned N_BITS  = N_GROUPS * GROUP_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  soft_rst_i,
  input  logic [N_BITS-1:0]     rise_i,
  input  logic [N_BITS-1:0]     fall_i,
  input  logic [2*N_GROUPS-1:0] en_i,
  input  logic                  clr_wr_i,
  input  logic [N_GROUPS-1:0]   clr_be_i,
  input  logic [N_BITS-1:0]     clr_data_i,
  output logic [N_BITS-1:0]     status_o
);
  logic [N_BITS-1:0] set_v, clr_v, status_q;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    localparam int unsigned LO = g * GROUP_W;
    assign set_v[LO +: GROUP_W] = (rise_i[LO +: GROUP_W] & grp_fill(en_i[g]))
                                | (fall_i[LO +: GROUP_W] & grp_fill(en_i[N_GROUPS+g]));
    assign clr_v[LO +: GROUP_W] = clr_data_i[LO +: GROUP_W]
                                & grp_fill(clr_wr_i & clr_be_i[g]);
  end

  // Set is applied after clear so a same-cycle event survives.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         status_q <= '0;
    else if (soft_rst_i) status_q <= '0;
    else                 status_q <= (status_q & ~clr_v) | set_v;
  end

  assign status_o = status_q;
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
  import cos_irq_pkg::*;
#(
  parameter int unsigned N_GROUPS = 4,
  localparam int unsigned N_BITS  = N_GROUPS * GROUP_W,
  localparam int unsigned EN_W    = 2 * N_GROUPS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic [N_BITS-1:0]   din_i,
  input  logic                en_wr_i,
  input  logic [EN_W-1:0]     en_wdata_i,
  output logic [EN_W-1:0]     en_o,
  input  logic                clr_wr_i,
  input  logic [N_GROUPS-1:0] clr_be_i,
  input  logic [N_BITS-1:0]   clr_data_i,
  output logic [N_BITS-1:0]   status_o,
  output logic                irq_o,
  output logic                irq_stat_o
);
  logic [N_BITS-1:0] din_s, rise, fall, status;
  logic [EN_W-1:0]   en_q;
  logic              irq_q;

  cos_sync #(.W(N_BITS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (din_i),
    .q_o   (din_s)
  );

  cos_edge_det #(.W(N_BITS), .PRIME_CYC(SYNC_STAGES + 1)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (din_s),
    .rise_o(rise),
    .fall_o(fall)
  );

  cos_status #(.N_GROUPS(N_GROUPS)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst_i),
    .rise_i    (rise),
    .fall_i    (fall),
    .en_i      (en_q),
    .clr_wr_i  (clr_wr_i),
    .clr_be_i  (clr_be_i),
    .clr_data_i(clr_data_i),
    .status_o  (status)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_wr_i) en_q <= en_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |status;
  end

  assign en_o       = en_q;
  assign status_o   = status;
  assign irq_o      = irq_q;
  assign irq_stat_o = irq_q;
endmodule

// File: rtl/cos_irq_ctrl_chk.sv
module cos_irq_ctrl_chk #(
  parameter int unsigned N_BITS = 32,
  parameter int unsigned EN_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              en_wr_i,
  input logic [EN_W-1:0]   en_o,
  input logic              clr_wr_i,
  input logic [N_BITS-1:0] status_o,
  input logic              irq_o
);
  p_irq_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|status_o) |=> irq_o);

  p_irq_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == '0) |=> !irq_o);

  p_soft_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (status_o == '0));

  p_no_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_wr_i && !soft_rst_i) |=> ((status_o & $past(status_o)) == $past(status_o)));

  p_en_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_wr_i |=> $stable(en_o));

  p_no_set_when_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o == '0) |=> ((status_o & ~$past(status_o)) == '0));
endmodule

bind cos_irq_ctrl cos_irq_ctrl_chk #(.N_BITS(N_BITS), .EN_W(EN_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .soft_rst_i(soft_rst_i),
  .en_wr_i   (en_wr_i),
  .en_o      (en_o),
  .clr_wr_i  (clr_wr_i),
  .status_o  (status_o),
  .irq_o     (irq_o)
);

// File: tb/cos_irq_ctrl_tb.sv
module cos_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          soft_rst = 1'b0;
  logic [NB-1:0] din = '0;
  logic          en_wr = 1'b0;
  logic [7:0]    en_wdata = '0;
  logic [7:0]    en_o;
  logic          clr_wr = 1'b0;
  logic [3:0]    clr_be = '0;
  logic [NB-1:0] clr_data = '0;
  logic [NB-1:0] status;
  logic          irq, irq_stat;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cos_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .din_i(din),
    .en_wr_i(en_wr), .en_wdata_i(en_wdata), .en_o(en_o),
    .clr_wr_i(clr_wr), .clr_be_i(clr_be), .clr_data_i(clr_data),
    .status_o(status), .irq_o(irq), .irq_stat_o(irq_stat)
  );

  task automatic check(input bit ok, input string req, input logic [NB-1:0] act,
                       input logic [NB-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: input history queue, sticky flags, lagged irq.
  logic [NB-1:0] hist[$];
  logic [NB-1:0] m_st;
  logic [7:0]    m_en;
  logic          m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = '0; m_en = '0; m_irq = 1'b0;
      hist = '{din, din, din};
    end else begin
      logic [NB-1:0] now_v, old_v, setm, clrm, st_old;
      now_v  = hist[1];
      old_v  = hist[2];
      st_old = m_st;
      setm = '0; clrm = '0;
      for (int i = 0; i < NB; i++) begin
        int g;
        g = i / 8;
        if (m_en[g]   && now_v[i] && !old_v[i]) setm[i] = 1'b1;
        if (m_en[4+g] && !now_v[i] && old_v[i]) setm[i] = 1'b1;
        if (clr_wr && clr_be[g] && clr_data[i]) clrm[i] = 1'b1;
      end
      m_irq = (st_old != 0);
      m_st  = soft_rst ? '0 : ((st_old & ~clrm) | setm);
      if (en_wr) m_en = en_wdata;
      hist.push_front(din);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(status == m_st, "R1 model status", status, m_st);
      check(irq == m_irq, "R6 model irq", NB'(irq), NB'(m_irq));
      check(irq_stat == irq, "R6 irq copy", NB'(irq_stat), NB'(irq));
      check(en_o == m_en, "R3 model enable", NB'(en_o), NB'(m_en));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic set_en(input logic [7:0] v);
    en_wr = 1'b1; en_wdata = v;
    tick();
    en_wr = 1'b0;
  endtask

  task automatic clear(input logic [3:0] be, input logic [NB-1:0] d);
    clr_wr = 1'b1; clr_be = be; clr_data = d;
    tick();
    clr_wr = 1'b0; clr_be = '0; clr_data = '0;
  endtask

  initial begin
    din = 32'h00FF00F0;
    tick(2);
    rst_n = 1'b1;
    @(negedge clk);
    check(en_o == 8'h00, "R3 enable reset", NB'(en_o), 0);
    check(status == 0, "R8 status after reset", status, 0);
    check(irq == 1'b0, "R6 irq after reset", NB'(irq), 0);
    set_en(8'hFF);
    tick(6);
    check(status == 0, "R8 held level is no edge", status, 0);

    // R2: nothing latches with all enables off
    set_en(8'h00);
    din = 32'h12345678;
    tick(5);
    check(status == 0, "R2 disabled edges ignored", status, 0);
    din = 32'h00FF00F0;
    tick(5);

    // R1/R2 rising only
    set_en(8'h0F);
    din = 32'h81FF0F3C;
    tick(3);
    check(status == 32'h81000F0C, "R1 rising groups", status, 32'h81000F0C);
    tick();
    check(irq == 1'b1, "R6 irq raised", NB'(irq), 1);

    // R4 byte-enabled clears
    clear(4'b0101, 32'hFFFFFFFF);
    check(status == 32'h81000F00, "R4 byte enables", status, 32'h81000F00);
    clear(4'b1111, 32'h00000000);
    check(status == 32'h81000F00, "R4 zero data", status, 32'h81000F00);
    clear(4'b1000, 32'h01000000);
    check(status == 32'h80000F00, "R4 single bit", status, 32'h80000F00);
    check(irq == 1'b1, "R6 irq holds", NB'(irq), 1);
    clear(4'b1111, 32'hFFFFFFFF);
    check(status == 0, "R4 clear all", status, 0);
    check(irq == 1'b1, "R6 irq lags one cycle", NB'(irq), 1);
    tick();
    check(irq == 1'b0, "R6 irq drops", NB'(irq), 0);

    // R2 falling only
    set_en(8'hF0);
    din = 32'h00FF0000;
    tick(3);
    check(status == 32'h81000F3C, "R2 falling groups", status, 32'h81000F3C);
    clear(4'hF, 32'hFFFFFFFF);

    // R2 both edges on group 0 only
    set_en(8'h11);
    din = 32'h00FF0101;
    tick(3);
    check(status == 32'h00000001, "R2 both rising", status, 32'h00000001);
    clear(4'hF, 32'hFFFFFFFF);
    din = 32'h00FF0000;
    tick(3);
    check(status == 32'h00000001, "R2 both falling", status, 32'h00000001);
    clear(4'hF, 32'hFFFFFFFF);
    tick();

    // R5 set beats clear: bit 3 already set, new edge lands with its clear
    din = 32'h00FF0008;
    tick(3);
    din = 32'h00FF0000;
    tick(2);
    clear(4'b0001, 32'h00000008);
    check(status == 32'h00000008, "R5 set wins", status, 32'h00000008);

    // R7 soft reset
    soft_rst = 1'b1;
    tick();
    soft_rst = 1'b0;
    check(status == 0, "R7 soft reset clears", status, 0);
    check(en_o == 8'h11, "R7 enable kept", NB'(en_o), 32'h11);

    // R9 latency probe on bit 2
    tick(2);
    din = 32'h00FF0004;
    @(posedge clk); @(negedge clk);
    check(status == 0, "R9 not after edge k", status, 0);
    tick();
    check(status == 0, "R9 not after edge k+1", status, 0);
    tick();
    check(status == 32'h4, "R9 set after edge k+2", status, 32'h4);
    check(irq == 1'b0, "R9 irq not yet", NB'(irq), 0);
    tick();
    check(irq == 1'b1, "R9 irq after edge k+3", NB'(irq), 1);

    tick(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule